// File: doc/BRIEF.md
# SPI Master DMA Transfer Engine

This block moves a programmed number of bytes between a local byte-wide synchronous memory and an SPI master shifter, so that no processor has to feed or drain the shifter. Software loads a transmit base address, a receive base address, a byte count and an idle-delay value through a small register write port. It then writes the control word with its start bit set. The engine reads each outgoing byte from memory and shifts it out in SPI mode 0. It writes each incoming byte back to memory and raises a one-cycle done pulse when the count is used up.

The control word chooses a duplex mode and whether the transmit and receive addresses step forward after each byte. It can also frame the traffic by pulsing slave select low around groups of 1, 2 or 4 bytes. An optional interrupt fires after a chosen number of idle SCK periods following completion. An abort input ends a session cleanly at the next byte boundary.

Register map (3-bit write address): 0 = control, 1 = transmit base, 2 = receive base, 3 = byte count, 4 = idle delay. Control word bits: [0] start, [1] delayed-interrupt enable, [3:2] duplex code, [4] receive increment, [5] transmit increment, [7:6] slave-select group code.

Top module: `spi_dma_engine`

## Requirements
- R1: After reset, busy, done, irq, sck, memRe and memWe are 0 and ssN is 1.
- R2: A control write with bit 0 set while idle starts a session. If the count is nonzero, busy is 1 from the next cycle until the cycle of the done pulse. done is a one-cycle pulse raised once all bytes have moved. A count of 0 gives a done pulse in the next cycle, with no SCK activity.
- R3: SCK idles low and has a period of 4 clocks. Each byte is sent MSB first with 8 rising edges, and MOSI is stable when SCK rises.
- R4: Duplex codes 10 and 11 are full duplex. Every byte is read from memory and sent, and the byte received at the same time is written to memory.
- R5: Duplex code 01 transmits only. Received bits are dropped and memWe never rises.
- R6: Duplex code 00 receives only. MOSI carries 0xFF for every byte and memRe never rises.
- R7: With control bit 5 set, byte i is read from transmit base + i. With bit 5 clear, every byte is read from the transmit base.
- R8: With control bit 4 set, byte i is written to receive base + i. With bit 4 clear, every byte is written to the receive base.
- R9: Slave-select group code 10 frames groups of 1 byte, code 01 groups of 2, and code 11 groups of 4. ssN is low across each group, the last group may be shorter, and ssN stays high for at least 4 clocks between groups.
- R10: With group code 00, ssN stays high for the whole session.
- R11: When the delayed interrupt is enabled, irq pulses for one cycle exactly 4*(D+1) clocks after the done pulse, where D is the 3-bit delay register. There is no irq after an aborted session.
- R12: A control write with a nonzero group code clears the delayed-interrupt enable whatever bit 1 holds, so no irq follows that session.
- R13: An abortReq during a session lets the byte in progress finish and then stops. busy falls, ssN returns high and no done pulse is given.
- R14: Register writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWdata | input | 12 | Register write data |
| memAddr | output | 12 | Memory address |
| memRe | output | 1 | Memory read strobe, data one cycle later |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| ssN | output | 1 | Slave select, active low |
| abortReq | input | 1 | Stop the session at the next byte boundary |
| busy | output | 1 | Session in progress, reads as the start bit |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle delayed idle interrupt |

## Verification
The assertions take for granted that the configuration stays put while a session runs. That holds only because R14 blocks register writes while busy. The bench therefore programs every register while the engine is idle. Its only write during a session is a deliberate one that tests R14. Every session keeps the transmit and receive address windows apart, so a byte written back to memory cannot change a byte still waiting to be sent. abortReq is driven only while a session is running.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  localparam int REG_AW = 3;

  // register write addresses
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_TXB  = 3'd1;
  localparam logic [REG_AW-1:0] RA_RXB  = 3'd2;
  localparam logic [REG_AW-1:0] RA_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] RA_DLY  = 3'd4;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_IRQEN = 1;
  localparam int CB_DUP   = 2;
  localparam int CB_RXINC = 4;
  localparam int CB_TXINC = 5;
  localparam int CB_SS    = 6;

  localparam logic [1:0] DUP_RX = 2'b00;
  localparam logic [1:0] DUP_TX = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_SHIFT, S_STORE, S_GAP
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic fetch;
    logic load;
    logic shift;
    logic store;
  } dpCmd_t;

  function automatic logic [2:0] groupBytes(input logic [1:0] code);
    case (code)
      2'b10:   return 3'd1;
      2'b01:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
  import spi_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 3,
  parameter int REG_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              abortReq,
  input  logic              byteEnd,
  output dpCmd_t            cmd,
  output logic [ADDR_W-1:0] txBase,
  output logic [ADDR_W-1:0] rxBase,
  output logic              txInc,
  output logic              rxInc,
  output logic              txOn,
  output logic              rxOn,
  output logic              ssN,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [1:0]        cfgDuplex,
  output logic [1:0]        cfgSsMode,
  output logic              cfgIrqEn
);

  localparam int GAP_W = 2;
  localparam logic [GAP_W-1:0] GAP_LAST = '1;
  localparam int IRQ_W = DLY_W + 2;

  state_e             stateQ;
  logic [1:0]         ssModeQ, duplexQ;
  logic               txIncQ, rxIncQ, irqEnQ;
  logic [ADDR_W-1:0]  txBaseQ, rxBaseQ;
  logic [CNT_W-1:0]   countQ, remainQ;
  logic [DLY_W-1:0]   dlyQ;
  logic [2:0]         grpCntQ;
  logic [GAP_W-1:0]   gapCntQ;
  logic               abortPendQ, ssLowQ, doneQ, irqQ, irqArmQ;
  logic [IRQ_W-1:0]   irqCntQ;

  logic idle, cfgWe, startReq, wrIrqEn, lastByte, grpFull, stopNow;
  logic [2:0] groupSize;

  assign idle      = (stateQ == S_IDLE);
  assign cfgWe     = regWe && idle;
  assign startReq  = cfgWe && (regAddr == RA_CTRL) && regWdata[CB_START];
  assign wrIrqEn   = regWdata[CB_IRQEN] && (regWdata[CB_SS+:2] == 2'b00);
  assign groupSize = groupBytes(ssModeQ);
  assign lastByte  = (remainQ == CNT_W'(1));
  assign grpFull   = (ssModeQ != 2'b00) && ((grpCntQ + 3'd1) == groupSize);
  assign stopNow   = abortPendQ || abortReq;

  // configuration registers, writable only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssModeQ <= '0; duplexQ <= '0; txIncQ <= 1'b0; rxIncQ <= 1'b0;
      irqEnQ  <= 1'b0; txBaseQ <= '0; rxBaseQ <= '0; countQ <= '0; dlyQ <= '0;
    end else if (cfgWe) begin
      case (regAddr)
        RA_CTRL: begin
          ssModeQ <= regWdata[CB_SS+:2];
          duplexQ <= regWdata[CB_DUP+:2];
          txIncQ  <= regWdata[CB_TXINC];
          rxIncQ  <= regWdata[CB_RXINC];
          irqEnQ  <= wrIrqEn;
        end
        RA_TXB:  txBaseQ <= regWdata[ADDR_W-1:0];
        RA_RXB:  rxBaseQ <= regWdata[ADDR_W-1:0];
        RA_CNT:  countQ  <= regWdata[CNT_W-1:0];
        RA_DLY:  dlyQ    <= regWdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  // session sequencer, framing and idle-delay timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE; remainQ <= '0; grpCntQ <= '0; gapCntQ <= '0;
      abortPendQ <= 1'b0; ssLowQ <= 1'b0; doneQ <= 1'b0;
      irqQ <= 1'b0; irqArmQ <= 1'b0; irqCntQ <= '0;
    end else begin
      doneQ <= 1'b0;
      irqQ  <= 1'b0;
      if (irqArmQ) begin
        irqCntQ <= irqCntQ + IRQ_W'(1);
        if (irqCntQ == {dlyQ, 2'b11}) begin
          irqQ    <= 1'b1;
          irqArmQ <= 1'b0;
        end
      end
      if (!idle && abortReq) abortPendQ <= 1'b1;

      case (stateQ)
        S_IDLE: begin
          if (startReq) begin
            irqArmQ    <= 1'b0;
            abortPendQ <= 1'b0;
            grpCntQ    <= '0;
            if (countQ == '0) begin
              doneQ   <= 1'b1;
              irqArmQ <= wrIrqEn;
              irqCntQ <= '0;
            end else begin
              remainQ <= countQ;
              stateQ  <= S_FETCH;
            end
          end
        end
        S_FETCH: stateQ <= S_LOAD;
        S_LOAD: begin
          ssLowQ <= (ssModeQ != 2'b00);
          stateQ <= S_SHIFT;
        end
        S_SHIFT: if (byteEnd) stateQ <= S_STORE;
        S_STORE: begin
          remainQ <= remainQ - CNT_W'(1);
          if (lastByte) begin
            stateQ  <= S_IDLE;
            ssLowQ  <= 1'b0;
            doneQ   <= 1'b1;
            irqArmQ <= irqEnQ;
            irqCntQ <= '0;
          end else if (stopNow) begin
            stateQ <= S_IDLE;
            ssLowQ <= 1'b0;
          end else if (grpFull) begin
            stateQ  <= S_GAP;
            ssLowQ  <= 1'b0;
            grpCntQ <= '0;
            gapCntQ <= '0;
          end else begin
            stateQ  <= S_FETCH;
            grpCntQ <= grpCntQ + 3'd1;
          end
        end
        S_GAP: begin
          gapCntQ <= gapCntQ + GAP_W'(1);
          if (gapCntQ == GAP_LAST) stateQ <= stopNow ? S_IDLE : S_FETCH;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.init  = startReq && (countQ != '0);
    cmd.fetch = (stateQ == S_FETCH);
    cmd.load  = (stateQ == S_LOAD);
    cmd.shift = (stateQ == S_SHIFT);
    cmd.store = (stateQ == S_STORE);
  end

  assign txBase    = txBaseQ;
  assign rxBase    = rxBaseQ;
  assign txInc     = txIncQ;
  assign rxInc     = rxIncQ;
  assign txOn      = (duplexQ != DUP_RX);
  assign rxOn      = (duplexQ != DUP_TX);
  assign ssN       = !ssLowQ;
  assign busy      = !idle;
  assign done      = doneQ;
  assign irq       = irqQ;
  assign cfgDuplex = duplexQ;
  assign cfgSsMode = ssModeQ;
  assign cfgIrqEn  = irqEnQ;

endmodule

// File: rtl/spi_dma_dp.sv
module spi_dma_dp
  import spi_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic              txInc,
  input  logic              rxInc,
  input  logic              txOn,
  input  logic              rxOn,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              miso,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              sck,
  output logic              mosi,
  output logic              byteEnd
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);
  localparam logic [1:0] PH_SAMPLE = 2'd1;
  localparam logic [1:0] PH_LAST   = 2'd3;

  logic [ADDR_W-1:0] txAddrQ, rxAddrQ;
  logic [DATA_W-1:0] txShQ, rxShQ;
  logic [1:0]        phaseQ;
  logic [BIT_W-1:0]  bitCntQ;

  assign byteEnd = cmd.shift && (phaseQ == PH_LAST) && (bitCntQ == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txAddrQ <= '0; rxAddrQ <= '0; txShQ <= '0; rxShQ <= '0;
      phaseQ  <= '0; bitCntQ <= '0;
    end else begin
      if (cmd.init) begin
        txAddrQ <= txBase;
        rxAddrQ <= rxBase;
      end
      if (cmd.load) begin
        txShQ   <= txOn ? memRdata : '1;
        phaseQ  <= '0;
        bitCntQ <= '0;
      end
      if (cmd.shift) begin
        phaseQ <= phaseQ + 2'd1;
        if (phaseQ == PH_SAMPLE) rxShQ <= {rxShQ[DATA_W-2:0], miso};
        if (phaseQ == PH_LAST && bitCntQ != BIT_LAST) begin
          txShQ   <= {txShQ[DATA_W-2:0], 1'b0};
          bitCntQ <= bitCntQ + BIT_W'(1);
        end
      end
      if (cmd.store) begin
        if (txInc) txAddrQ <= txAddrQ + ADDR_W'(1);
        if (rxInc) rxAddrQ <= rxAddrQ + ADDR_W'(1);
      end
    end
  end

  assign memRe    = cmd.fetch && txOn;
  assign memWe    = cmd.store && rxOn;
  assign memAddr  = cmd.store ? rxAddrQ : txAddrQ;
  assign memWdata = rxShQ;
  assign sck      = cmd.shift && phaseQ[1];
  assign mosi     = txShQ[DATA_W-1];

endmodule

// File: rtl/spi_dma_engine.sv
module spi_dma_engine
  import spi_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 12,
  parameter int DLY_W  = 3,
  parameter int DATA_W = 8,
  parameter int REG_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN,
  input  logic              abortReq,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  dpCmd_t            cmd;
  logic [ADDR_W-1:0] txBase, rxBase;
  logic              txInc, rxInc, txOn, rxOn, byteEnd;
  logic [1:0]        cfgDuplex, cfgSsMode;
  logic              cfgIrqEn;

  spi_dma_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .REG_W(REG_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .abortReq(abortReq), .byteEnd(byteEnd), .cmd(cmd),
    .txBase(txBase), .rxBase(rxBase), .txInc(txInc), .rxInc(rxInc),
    .txOn(txOn), .rxOn(rxOn), .ssN(ssN), .busy(busy), .done(done), .irq(irq),
    .cfgDuplex(cfgDuplex), .cfgSsMode(cfgSsMode), .cfgIrqEn(cfgIrqEn)
  );

  spi_dma_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txBase(txBase), .rxBase(rxBase),
    .txInc(txInc), .rxInc(rxInc), .txOn(txOn), .rxOn(rxOn),
    .memRdata(memRdata), .miso(miso), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .sck(sck), .mosi(mosi), .byteEnd(byteEnd)
  );

endmodule

// File: rtl/spi_dma_checker.sv
module spi_dma_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       sck,
  input logic       ssN,
  input logic       memRe,
  input logic       memWe,
  input logic [1:0] cfgDuplex,
  input logic [1:0] cfgSsMode,
  input logic       cfgIrqEn
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssN && !sck && !memRe && !memWe));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  a_r3_sck_high_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |=> sck);

  a_r5_txonly_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgDuplex == 2'b01) |-> !memWe);

  a_r6_rxonly_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgDuplex == 2'b00) |-> !memRe);

  a_r10_ss_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSsMode == 2'b00) |-> ssN);

  a_r12_irq_en_forced: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSsMode != 2'b00) |-> !cfgIrqEn);

endmodule

bind spi_dma_engine spi_dma_checker chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .sck(sck), .ssN(ssN),
  .memRe(memRe), .memWe(memWe), .cfgDuplex(cfgDuplex), .cfgSsMode(cfgSsMode),
  .cfgIrqEn(cfgIrqEn)
);

// File: tb/spi_dma_engine_tb_top.sv
module spi_dma_engine_tb_top;
  import spi_dma_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [11:0] regWdata = '0;
  logic [11:0] memAddr;
  logic        memRe, memWe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        sck, mosi, ssN, busy, done, irq;
  logic        miso = 1'b1;
  logic        abortReq = 1'b0;

  always #5 clk = ~clk;

  spi_dma_engine dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN),
    .abortReq(abortReq), .busy(busy), .done(done), .irq(irq)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [0:255];
  logic [7:0] memInit [0:255];
  logic [7:0] misoBytes [0:63];
  logic [7:0] mosiLog [0:63];
  logic [7:0] wAddr [0:63];
  logic [7:0] wData [0:63];
  int groups [0:63];
  int nWrites, nReads, cyc, doneCnt, doneCyc, irqCnt, irqCyc;
  int slaveBytes, slaveBit, totalRises, riseBad, lastRise;
  int nGroups, grpStart, gapRun, gapMin;
  bit ssLowSeen, sckPrev, ssPrev;
  logic [7:0] slaveSh;

  // synchronous memory model
  always @(posedge clk) begin
    if (memRe) begin
      memRdata <= mem[memAddr[7:0]];
      nReads <= nReads + 1;
    end
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      if (nWrites < 64) begin
        wAddr[nWrites] <= memAddr[7:0];
        wData[nWrites] <= memWdata;
      end
      nWrites <= nWrites + 1;
    end
  end

  // SPI slave model and port monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin doneCnt++; doneCyc = cyc; end
    if (irq)  begin irqCnt++;  irqCyc  = cyc; end
    if (sck && !sckPrev) begin
      totalRises++;
      if (slaveBit != 0 && cyc - lastRise != 4) riseBad++;
      lastRise = cyc;
      slaveSh = {slaveSh[6:0], mosi};
      if (slaveBit == 7) begin
        if (slaveBytes < 64) mosiLog[slaveBytes] = slaveSh;
        slaveBytes++;
        slaveBit = 0;
      end else slaveBit++;
      miso = misoBytes[slaveBytes % 64][7 - slaveBit];
    end
    sckPrev = sck;
    if (!ssN && ssPrev) begin
      grpStart = slaveBytes;
      if (nGroups > 0 && gapRun < gapMin) gapMin = gapRun;
    end
    if (ssN && !ssPrev && nGroups < 64) begin
      groups[nGroups] = slaveBytes - grpStart;
      nGroups++;
      gapRun = 0;
    end
    if (ssN) gapRun++;
    if (!ssN) ssLowSeen = 1'b1;
    ssPrev = ssN;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic runSession(input logic [1:0] dup, input bit txI, input bit rxI,
                            input logic [1:0] ss, input bit irqE, input int dly,
                            input int cnt, input int txB, input int rxB,
                            input int abortAt, input bit busyWrite);
    int nExp, rem, g, gi, gsz;
    bit txOn, rxOn, irqExp, aborted;
    logic [7:0] e;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); memInit[i] = mem[i]; end
    for (int i = 0; i < 64; i++) misoBytes[i] = 8'($urandom);
    nWrites = 0; nReads = 0; doneCnt = 0; irqCnt = 0; slaveBytes = 0; slaveBit = 0;
    totalRises = 0; riseBad = 0; nGroups = 0; gapMin = 1000; gapRun = 0;
    ssLowSeen = 1'b0; miso = misoBytes[0][7];
    writeReg(RA_TXB, 12'(txB));
    writeReg(RA_RXB, 12'(rxB));
    writeReg(RA_CNT, 12'(cnt));
    writeReg(RA_DLY, 12'(dly));
    writeReg(RA_CTRL, {4'b0, ss, txI, rxI, dup, irqE, 1'b1});
    check(busy == (cnt > 0), "R2 busy after start", busy, cnt > 0);
    if (busyWrite) begin
      writeReg(RA_TXB, 12'h0F0);
      writeReg(RA_CNT, 12'd1);
      writeReg(RA_CTRL, 12'h001);
    end
    aborted = 1'b0;
    for (int k = 0; k < 20000 && busy; k++) begin
      @(negedge clk);
      abortReq = 1'b0;
      if (abortAt >= 0 && !aborted && slaveBytes == abortAt && slaveBit == 3) begin
        abortReq = 1'b1; aborted = 1'b1;
      end
    end
    abortReq = 1'b0;
    repeat (40) @(negedge clk);
    check(!busy, "R2 busy clears", busy, 0);
    nExp  = (abortAt >= 0) ? abortAt + 1 : cnt;
    txOn  = (dup != 2'b00);
    rxOn  = (dup != 2'b01);
    check(slaveBytes == nExp, busyWrite ? "R14 byte total" : "R2 byte total", slaveBytes, nExp);
    check(doneCnt == (abortAt >= 0 ? 0 : 1), abortAt >= 0 ? "R13 no done" : "R2 done count",
          doneCnt, abortAt >= 0 ? 0 : 1);
    if (abortAt >= 0) check(ssN == 1'b1, "R13 ssN released", ssN, 1);
    check(riseBad == 0, "R3 sck spacing", riseBad, 0);
    check(totalRises == 8 * nExp, "R3 rising edges", totalRises, 8 * nExp);
    for (int i = 0; i < nExp && i < 64; i++) begin
      e = txOn ? memInit[8'(txB + (txI ? i : 0))] : 8'hFF;
      check(mosiLog[i] == e, txOn ? "R7 tx byte" : "R6 dummy byte", mosiLog[i], e);
    end
    if (!txOn) check(nReads == 0, "R6 no reads", nReads, 0);
    if (rxOn) begin
      check(nWrites == nExp, "R4 write count", nWrites, nExp);
      for (int i = 0; i < nExp && i < 64; i++) begin
        check(wAddr[i] == 8'(rxB + (rxI ? i : 0)), "R8 rx address", wAddr[i], rxB + (rxI ? i : 0));
        check(wData[i] == misoBytes[i], "R4 rx data", wData[i], misoBytes[i]);
      end
    end else check(nWrites == 0, "R5 no writes", nWrites, 0);
    if (ss == 2'b00) check(!ssLowSeen, "R10 ssN held high", ssLowSeen, 0);
    else begin
      gsz = (ss == 2'b10) ? 1 : (ss == 2'b01) ? 2 : 4;
      rem = nExp; gi = 0;
      while (rem > 0) begin
        g = (rem < gsz) ? rem : gsz;
        check(groups[gi] == g, "R9 group size", groups[gi], g);
        rem -= g; gi++;
      end
      check(nGroups == gi, "R9 group count", nGroups, gi);
      if (nGroups > 1) check(gapMin >= 4, "R9 gap length", gapMin, 4);
    end
    irqExp = irqE && (ss == 2'b00) && (abortAt < 0);
    check(irqCnt == int'(irqExp), (irqE && ss != 2'b00) ? "R12 irq suppressed" : "R11 irq count",
          irqCnt, int'(irqExp));
    if (irqExp && irqCnt == 1)
      check(irqCyc - doneCyc == 4 * (dly + 1), "R11 irq delay", irqCyc - doneCyc, 4 * (dly + 1));
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq && !sck && !memRe && !memWe && ssN, "R1 in reset",
          {busy, done, irq, sck, memRe, memWe, ssN}, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !irq && !sck && ssN, "R1 after reset", {busy, done, irq, sck, ssN}, 1);
    // directed corner cases
    runSession(2'b10, 1, 1, 2'b10, 0, 0, 5, 10, 140, -1, 1);
    runSession(2'b01, 1, 0, 2'b01, 0, 0, 5, 20, 150, -1, 0);
    runSession(2'b00, 0, 0, 2'b11, 0, 0, 9, 30, 160, -1, 0);
    runSession(2'b11, 0, 1, 2'b00, 1, 3, 4, 40, 170, -1, 0);
    runSession(2'b10, 1, 1, 2'b10, 1, 2, 3, 50, 180, -1, 0);
    runSession(2'b10, 1, 1, 2'b01, 1, 0, 6, 60, 130, 2, 0);
    runSession(2'b10, 1, 1, 2'b00, 0, 0, 0, 70, 190, -1, 0);
    runSession(2'b10, 1, 1, 2'b00, 1, 7, 1, 70, 190, -1, 0);
    // constrained random sessions
    for (int s = 0; s < 10; s++) begin
      runSession(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                 int'($urandom % 8), int'($urandom % 12) + 1, int'($urandom % 100),
                 128 + int'($urandom % 80), -1, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule